// File: doc/BRIEF.md
# Stereo PCM Attenuator with Ramped and Hard Muting

This block scales a stereo stream of signed 16-bit PCM samples by a gain set with a 10-bit linear code. The level of a code `c` is `20*log10(c/1024)` dB. Code 0 silences the output. The gain never jumps. On every accepted sample pair, the effective gain moves one fixed step toward its target. The target is the attenuation code, or zero while the soft mute is held. With a step of one code, a full swing takes about 1023 sample periods, which is 23.2 ms at 44.1 kHz. The same rate applies when muting and when releasing the mute.

A hard mute zeroes the output on the sample where it applies, with no ramp. It has two sources:
- the explicit mute command, which acts only while the option-enable bit is set;
- the zero-data detector, which acts when its enable is set and both channels have carried a long run of consecutive all-zero samples.

The gain ramp keeps running underneath a hard mute. When the hard mute lifts, the output resumes at whatever gain the ramp has reached.

A sample pair is accepted on a clock edge where `in_valid` is high. The scaled pair and a mute flag appear on the registered outputs one cycle later.

Top module: `pcm_gain_attenuator`

## Requirements
- R1: After reset `out_valid`, `out_left`, `out_right` and `mute_active` are 0, and the effective gain is 0, so the first accepted pair produces zero output with `mute_active` high.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R3: On each accepted pair, the effective gain moves toward its target by `RAMP_STEP` codes (default 1), without passing the target; from 0 to code 3FFh it takes 1023 accepted pairs.
- R4: Each output equals `floor((sample*gain + 512) / 1024)`, using the gain in force before that pair's step, saturated to the range -32768..32767; the sample is two's complement.
- R5: With attenuation code 000h, the gain ramps to 0 and the output is then fully muted.
- R6: While `soft_mute` is high the target is 0; after release the target returns to `atten_code`, at the same ramp rate.
- R7: With `opt_en` and `force_mute` both high, an accepted pair produces zero on both outputs at once, while the gain ramp continues.
- R8: With `opt_en` low, `force_mute` has no effect on the output.
- R9: With `zero_mute_en` high, a pair is hard-muted when each channel's current sample completes a run of at least `ZERO_RUN` consecutive all-zero samples; any nonzero sample restarts that channel's run.
- R10: A zero run on only one channel, or a run of both channels with `zero_mute_en` low, does not raise the hard mute.
- R11: `mute_active` is high with an output pair exactly when that pair was hard-muted or the gain used for it was 0.
- R12: In cycles with `in_valid` low, the gain does not step, even if the code or `soft_mute` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 16 | Left sample, two's complement |
| in_right | input | 16 | Right sample, two's complement |
| atten_code | input | 10 | Linear gain code, level 20*log10(code/1024) dB |
| soft_mute | input | 1 | Ramp gain to zero while high |
| force_mute | input | 1 | Hard mute command, gated by opt_en |
| zero_mute_en | input | 1 | Enables hard mute on zero-data runs |
| opt_en | input | 1 | Option enable for force_mute |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |
| mute_active | output | 1 | Output pair hard-muted or at zero gain |

## Verification
The hard mute and a gain ramp step can fall on the same accepted sample: the forced or zero-run mute blanks the pair while the ramp still moves one code. The bench holds the soft mute, or a code change, together with the hard mute across hundreds of pairs, then lifts the hard mute. The first unmuted outputs are then judged against a gain that the bench has advanced step by step through the whole muted stretch. A zero run that completes while the ramp is mid-swing is judged the same way.

// File: rtl/pga_pkg.sv
package pga_pkg;
   // rounding variant for the scaler
   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } rnd_e;

   localparam int CHANNELS = 2;
endpackage

// File: rtl/pga_zero_run.sv
module pga_zero_run #(
   parameter int SAMPLE_W = 16,
   parameter int ZERO_RUN = 2048
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                run_hit
);
   localparam int CNT_W = $clog2(ZERO_RUN + 1);
   localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(ZERO_RUN);
   localparam logic [CNT_W-1:0] RUN_NEED = CNT_W'(ZERO_RUN - 1);

   logic [CNT_W-1:0] zero_cnt;
   logic             is_zero;

   assign is_zero = (sample == '0);
   assign run_hit = is_zero && (zero_cnt >= RUN_NEED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_cnt <= '0;
      end else if (take) begin
         if (!is_zero)
            zero_cnt <= '0;
         else if (zero_cnt != RUN_MAX)
            zero_cnt <= zero_cnt + 1'b1;
      end
   end

   assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      zero_cnt <= RUN_MAX);
   assert_run_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && sample != '0) |=> zero_cnt == '0);
endmodule

// File: rtl/pga_gain_ramp.sv
module pga_gain_ramp #(
   parameter int CODE_W    = 10,
   parameter int RAMP_STEP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic [CODE_W-1:0] target,
   output logic [CODE_W-1:0] gain
);
   localparam logic [CODE_W-1:0] STEP = CODE_W'(RAMP_STEP);

   logic [CODE_W-1:0] gap_up, gap_dn, gain_nx;

   assign gap_up = target - gain;
   assign gap_dn = gain - target;

   always_comb begin
      gain_nx = gain;
      if (gain < target)
         gain_nx = (gap_up > STEP) ? gain + STEP : target;
      else if (gain > target)
         gain_nx = (gap_dn > STEP) ? gain - STEP : target;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gain <= '0;
      else if (step_en)
         gain <= gain_nx;
   end

   assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ((gain >= $past(gain)) ? (gain - $past(gain)) : ($past(gain) - gain)) <= STEP);
   assert_no_overshoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && gain <= target) |=> gain <= $past(target));
   assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(gain));
endmodule

// File: rtl/pga_scaler.sv
module pga_scaler
   import pga_pkg::*;
#(
   parameter int   SAMPLE_W = 16,
   parameter int   CODE_W   = 10,
   parameter rnd_e RND      = RND_HALF_UP
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CODE_W-1:0]   gain,
   output logic [SAMPLE_W-1:0] scaled
);
   localparam int PROD_W = SAMPLE_W + CODE_W + 1;
   localparam int SUM_W  = PROD_W + 1;

   logic signed [PROD_W-1:0] prod;
   logic signed [SUM_W-1:0]  sum, shifted, hi_lim, lo_lim;

   assign prod   = $signed(sample) * $signed({1'b0, gain});
   assign hi_lim = {{(SUM_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   assign lo_lim = {{(SUM_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

   generate
      if (RND == RND_HALF_UP) begin : g_round
         assign sum = {prod[PROD_W-1], prod}
                    + {{(SUM_W-CODE_W){1'b0}}, 1'b1, {(CODE_W-1){1'b0}}};
      end else begin : g_trunc
         assign sum = {prod[PROD_W-1], prod};
      end
   endgenerate

   assign shifted = sum >>> CODE_W;

   always_comb begin
      if (shifted > hi_lim)
         scaled = hi_lim[SAMPLE_W-1:0];
      else if (shifted < lo_lim)
         scaled = lo_lim[SAMPLE_W-1:0];
      else
         scaled = shifted[SAMPLE_W-1:0];
   end
endmodule

// File: rtl/pcm_gain_attenuator.sv
module pcm_gain_attenuator
   import pga_pkg::*;
#(
   parameter int   SAMPLE_W  = 16,
   parameter int   CODE_W    = 10,
   parameter int   RAMP_STEP = 1,
   parameter int   ZERO_RUN  = 2048,
   parameter rnd_e RND       = RND_HALF_UP
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic [CODE_W-1:0]   atten_code,
   input  logic                soft_mute,
   input  logic                force_mute,
   input  logic                zero_mute_en,
   input  logic                opt_en,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right,
   output logic                mute_active
);
   generate
      if (SAMPLE_W < 4) begin : g_bad_sample_w
         $error("SAMPLE_W must be at least 4");
      end
      if (CODE_W < 2) begin : g_bad_code_w
         $error("CODE_W must be at least 2");
      end
      if (RAMP_STEP < 1 || RAMP_STEP >= (1 << CODE_W)) begin : g_bad_step
         $error("RAMP_STEP out of range");
      end
      if (ZERO_RUN < 1) begin : g_bad_run
         $error("ZERO_RUN must be at least 1");
      end
   endgenerate

   logic [SAMPLE_W-1:0] ch_in  [CHANNELS];
   logic [SAMPLE_W-1:0] ch_out [CHANNELS];
   logic [CHANNELS-1:0] ch_hit;
   logic [CODE_W-1:0]   gain, target;
   logic                hard_mute;

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;
   assign target   = soft_mute ? '0 : atten_code;

   pga_gain_ramp #(
      .CODE_W   (CODE_W),
      .RAMP_STEP(RAMP_STEP)
   ) u_ramp (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_en(in_valid),
      .target (target),
      .gain   (gain)
   );

   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
         pga_zero_run #(
            .SAMPLE_W(SAMPLE_W),
            .ZERO_RUN(ZERO_RUN)
         ) u_zero (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (in_valid),
            .sample (ch_in[c]),
            .run_hit(ch_hit[c])
         );
         pga_scaler #(
            .SAMPLE_W(SAMPLE_W),
            .CODE_W  (CODE_W),
            .RND     (RND)
         ) u_scale (
            .sample(ch_in[c]),
            .gain  (gain),
            .scaled(ch_out[c])
         );
      end
   endgenerate

   assign hard_mute = (force_mute && opt_en) || (zero_mute_en && (&ch_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_left    <= '0;
         out_right   <= '0;
         mute_active <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_left    <= hard_mute ? '0 : ch_out[0];
            out_right   <= hard_mute ? '0 : ch_out[1];
            mute_active <= hard_mute || (gain == '0);
         end
      end
   end

   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hard_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && force_mute && opt_en) |=> (out_left == '0 && out_right == '0 && mute_active));
   assert_zero_gain_mute_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && gain == '0) |=> (mute_active && out_left == '0 && out_right == '0));
endmodule

// File: tb/pcm_gain_attenuator_tb.sv
module pcm_gain_attenuator_tb;
   localparam int ZR = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_left = '0, in_right = '0;
   logic [9:0]  atten_code = '0;
   logic        soft_mute = 1'b0, force_mute = 1'b0, zero_mute_en = 1'b0, opt_en = 1'b0;
   logic        out_valid, mute_active;
   logic [15:0] out_left, out_right;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   int mg = 0, zl = 0, zr = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   pcm_gain_attenuator #(.ZERO_RUN(ZR)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_left(in_left), .in_right(in_right), .atten_code(atten_code),
      .soft_mute(soft_mute), .force_mute(force_mute),
      .zero_mute_en(zero_mute_en), .opt_en(opt_en),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
      .mute_active(mute_active));

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic longint scale(logic [15:0] s, int g);
      longint v = (longint'($signed(s)) * g + 512) >>> 10;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      return v;
   endfunction

   function automatic logic [15:0] rnd16();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr;
   endfunction

   // one accepted pair; expected values from the requirement arithmetic
   task automatic send(logic [15:0] l, logic [15:0] r, string req);
      bit hard, hl, hr;
      int tgt;
      longint el, er;
      @(negedge clk);
      in_left = l; in_right = r; in_valid = 1'b1;
      hl = (l == 0) && (zl >= ZR - 1);
      hr = (r == 0) && (zr >= ZR - 1);
      hard = (force_mute && opt_en) || (zero_mute_en && hl && hr);
      el = hard ? 0 : scale(l, mg);
      er = hard ? 0 : scale(r, mg);
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid R2"}, out_valid, 1);
      check({req, " left"}, longint'($signed(out_left)), el);
      check({req, " right"}, longint'($signed(out_right)), er);
      check({req, " mute R11"}, mute_active, (hard || mg == 0) ? 1 : 0);
      zl = (l == 0) ? ((zl < ZR) ? zl + 1 : ZR) : 0;
      zr = (r == 0) ? ((zr < ZR) ? zr + 1 : ZR) : 0;
      tgt = soft_mute ? 0 : int'(atten_code);
      if (mg < tgt) mg = mg + 1;
      else if (mg > tgt) mg = mg - 1;
   endtask

   task automatic idle_check();
      @(negedge clk);
      check("idle valid R2", out_valid, 0);
   endtask

   task automatic send_rand(int n, string req);
      for (int i = 0; i < n; i++) send(rnd16(), rnd16(), req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("reset valid R1", out_valid, 0);
      check("reset left R1", out_left, 0);
      check("reset right R1", out_right, 0);
      check("reset mute R1", mute_active, 0);
      rst_n = 1'b1;
      atten_code = 10'h3FF;
      send(16'h7FFF, 16'h8000, "first pair R1");
      // R3/R4: full ramp up with varied samples, then extremes at top gain
      send_rand(1030, "ramp up R3");
      check("gain top R3", mg, 1023);
      send(16'h7FFF, 16'h8000, "extremes R4");
      send(16'hFFFF, 16'h0001, "unit R4");
      send(16'h0200, 16'hFE00, "half R4");
      idle_check();
      // R3: ramp down to a mid code
      atten_code = 10'h200;
      send_rand(530, "ramp down R3");
      // R5: code zero mutes fully
      atten_code = 10'h000;
      send_rand(520, "code zero R5");
      check("gain zero R5", mg, 0);
      atten_code = 10'h300;
      send_rand(800, "ramp to 300 R3");
      // R6: soft mute and release
      soft_mute = 1'b1;
      send_rand(800, "soft mute R6");
      soft_mute = 1'b0;
      send_rand(800, "soft release R6");
      // R12: controls change while idle, gain holds
      @(negedge clk); atten_code = 10'h040; soft_mute = 1'b1;
      @(negedge clk); soft_mute = 1'b0;
      idle_check();
      send_rand(4, "idle hold R12");
      // R8: force without option
      force_mute = 1'b1;
      send_rand(20, "force no opt R8");
      // R7: force with option, overlapping a ramp
      opt_en = 1'b1; atten_code = 10'h2A0;
      send_rand(300, "force ramp R7");
      force_mute = 1'b0;
      send_rand(20, "after force R7");
      // R9: zero runs on both channels with enable, during a ramp
      zero_mute_en = 1'b1; atten_code = 10'h180;
      for (int i = 0; i < ZR + 4; i++) send(16'h0000, 16'h0000, "zero run R9");
      send(16'h1234, 16'h0000, "run break R9");
      for (int i = 0; i < ZR + 2; i++) send(16'h0000, rnd16() | 16'h0001, "one side R10");
      zero_mute_en = 1'b0;
      for (int i = 0; i < ZR + 2; i++) send(16'h0000, 16'h0000, "run no en R10");
      send_rand(10, "tail R4");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule